// File: doc/BRIEF.md
# Pipeline Hazard Stall and Flush Controller

This block is the control logic that keeps a five-stage in-order pipeline correct when instructions overlap. It looks at the decoded fields of the instructions held in fetch, decode, execute and memory. From these it decides, every cycle, whether the program counter and the fetch/decode register may advance, whether the decode/execute register must take a bubble, and whether the instruction just fetched must be squashed. A bubble is the all-zero instruction word, which changes neither registers nor memory.

Branches are resolved in the decode stage by an external comparator, which reports a taken flag. Because the comparator reads operands in decode, a branch must wait for producers that sit one or two stages ahead. If the producer is an ALU instruction still in execute, the branch waits one cycle. If it is a load, the branch waits two cycles: one with the load in execute and one with the load in memory. An ordinary instruction waits only behind a load in execute, since forwarding into execute covers every other case. The register file writes in the first half of a cycle and reads in the second, so a producer in write-back never causes a stall. An unconditional jump is recognised by its opcode while it is being fetched, and the fetch address is redirected at once.

The controller is purely combinational from its stage inputs. Reset gating holds the pipeline frozen while reset is active.

Top module: `hazard_ctrl`

## Requirements
- R1: When execute holds a load (mem_read and reg_write both 1) whose nonzero destination equals a decode source marked as used, the controller stalls: pc_we_o=0, ifid_we_o=0, idex_bubble_o=1.
- R2: When decode holds a branch and execute holds any register writer (ALU or load) whose nonzero destination equals a used branch source, the controller stalls.
- R3: When decode holds a branch and memory holds a load whose nonzero destination equals a used branch source, the controller stalls. A memory-stage ALU producer causes no stall.
- R4: A non-branch decode instruction does not stall on any memory-stage producer. An execute-stage ALU producer does not stall it either.
- R5: A destination of register 0 never causes a stall.
- R6: A decode source whose use flag is 0 never causes a stall.
- R7: A taken branch in decode with no stall asserts ifid_flush_o=1 while pc_we_o=1 and ifid_we_o=1, which squashes exactly one slot.
- R8: When a stall condition and a taken branch coincide, the stall wins and ifid_flush_o=0.
- R9: A fetched opcode of 6'b000010 asserts jump_redirect_o in the same cycle, unless the controller is stalling or flushing in that cycle.
- R10: With no hazard, pc_we_o=1, ifid_we_o=1, idex_bubble_o=0, ifid_flush_o=0 and jump_redirect_o=0 (for a non-jump opcode).
- R11: A branch in decode whose taken flag is 0 does not flush.
- R12: While rst_ni=0, pc_we_o=0, ifid_we_o=0, idex_bubble_o=1, ifid_flush_o=0 and jump_redirect_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, used for property sampling |
| rst_ni | input | 1 | Active-low asynchronous reset |
| if_opcode_i | input | 6 | Opcode of the instruction being fetched |
| id_rs_i | input | 5 | First source register of decode instruction |
| id_rt_i | input | 5 | Second source register of decode instruction |
| id_use_rs_i | input | 1 | Decode instruction reads its first source |
| id_use_rt_i | input | 1 | Decode instruction reads its second source |
| id_is_branch_i | input | 1 | Decode instruction is a conditional branch |
| id_br_taken_i | input | 1 | Decode-stage comparator says branch is taken |
| ex_reg_write_i | input | 1 | Execute instruction writes a register |
| ex_mem_read_i | input | 1 | Execute instruction is a load |
| ex_dst_i | input | 5 | Execute instruction destination register |
| mem_reg_write_i | input | 1 | Memory instruction writes a register |
| mem_mem_read_i | input | 1 | Memory instruction is a load |
| mem_dst_i | input | 5 | Memory instruction destination register |
| pc_we_o | output | 1 | Program counter write enable |
| ifid_we_o | output | 1 | Fetch/decode register write enable |
| idex_bubble_o | output | 1 | Load bubble into decode/execute register |
| ifid_flush_o | output | 1 | Replace fetch/decode contents with bubble |
| jump_redirect_o | output | 1 | Select jump target as next fetch address |

## Verification
A wrong match or priority inside this block shows up at the ports in the same cycle as the stage contents that trigger it, because nothing is registered between the inputs and the enables. A missing stall lets pc_we_o stay high during a load-to-branch sequence. A lost priority shows up as a flush during a stall. Each bad case is therefore driven as a short cycle-by-cycle sequence of stage contents. The expected enables are compared in every cycle of the sequence, so a one-cycle error in a two-cycle stall is reported at the cycle where it occurs.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_LOAD_USE = 2'd1,
    CAUSE_BR_EX    = 2'd2,
    CAUSE_BR_MEM   = 2'd3
  } stall_cause_e;
endpackage

// File: rtl/hz_operand_match.sv
module hz_operand_match #(
  parameter int unsigned REG_AW = 5
) (
  input  logic              used_i,
  input  logic [REG_AW-1:0] src_i,
  input  logic              ex_wr_i,
  input  logic              ex_load_i,
  input  logic [REG_AW-1:0] ex_dst_i,
  input  logic              mem_load_i,
  input  logic [REG_AW-1:0] mem_dst_i,
  output logic              hit_ex_o,
  output logic              hit_ex_load_o,
  output logic              hit_mem_load_o
);
  logic src_live;
  assign src_live = used_i && (src_i != '0);  // r0 is hardwired, never a dependency

  assign hit_ex_o       = src_live && ex_wr_i   && (src_i == ex_dst_i);
  assign hit_ex_load_o  = hit_ex_o && ex_load_i;
  assign hit_mem_load_o = src_live && mem_load_i && (src_i == mem_dst_i);
endmodule

// File: rtl/hz_stall_detect.sv
module hz_stall_detect
  import hz_pkg::*;
#(
  parameter int unsigned N_OPS = 2
) (
  input  logic [N_OPS-1:0] hit_ex_i,
  input  logic [N_OPS-1:0] hit_ex_load_i,
  input  logic [N_OPS-1:0] hit_mem_load_i,
  input  logic             id_is_branch_i,
  output logic             stall_o,
  output stall_cause_e     cause_o
);
  always_comb begin
    cause_o = CAUSE_NONE;
    if (|hit_ex_load_i)
      cause_o = CAUSE_LOAD_USE;
    else if (id_is_branch_i && |hit_ex_i)
      cause_o = CAUSE_BR_EX;
    else if (id_is_branch_i && |hit_mem_load_i)
      cause_o = CAUSE_BR_MEM;
  end

  assign stall_o = (cause_o != CAUSE_NONE);
endmodule

// File: rtl/hz_redirect.sv
module hz_redirect #(
  parameter int unsigned OPC_W    = 6,
  parameter logic [OPC_W-1:0] JUMP_OPC = 6'b000010
) (
  input  logic [OPC_W-1:0] if_opcode_i,
  input  logic             id_is_branch_i,
  input  logic             id_br_taken_i,
  input  logic             stall_i,
  output logic             flush_o,
  output logic             jump_o
);
  logic is_jump;
  assign is_jump = (if_opcode_i == JUMP_OPC);
  // unresolved branch under stall must not squash
  assign flush_o = id_is_branch_i && id_br_taken_i && !stall_i;
  // fetched jump is itself squashed by a taken branch
  assign jump_o  = is_jump && !stall_i && !flush_o;
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned REG_AW   = 5,
  parameter int unsigned OPC_W    = 6,
  parameter logic [OPC_W-1:0] JUMP_OPC = 6'b000010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OPC_W-1:0]  if_opcode_i,
  input  logic [REG_AW-1:0] id_rs_i,
  input  logic [REG_AW-1:0] id_rt_i,
  input  logic              id_use_rs_i,
  input  logic              id_use_rt_i,
  input  logic              id_is_branch_i,
  input  logic              id_br_taken_i,
  input  logic              ex_reg_write_i,
  input  logic              ex_mem_read_i,
  input  logic [REG_AW-1:0] ex_dst_i,
  input  logic              mem_reg_write_i,
  input  logic              mem_mem_read_i,
  input  logic [REG_AW-1:0] mem_dst_i,
  output logic              pc_we_o,
  output logic              ifid_we_o,
  output logic              idex_bubble_o,
  output logic              ifid_flush_o,
  output logic              jump_redirect_o
);
  localparam int unsigned N_OPS = 2;

  logic [N_OPS-1:0][REG_AW-1:0] src;
  logic [N_OPS-1:0]             used;
  logic [N_OPS-1:0]             hit_ex, hit_ex_load, hit_mem_load;
  logic                         ex_load, mem_load;
  logic                         stall, flush_raw, jump_raw;
  stall_cause_e                 cause;

  assign src      = {id_rt_i, id_rs_i};
  assign used     = {id_use_rt_i, id_use_rs_i};
  assign ex_load  = ex_mem_read_i && ex_reg_write_i;
  assign mem_load = mem_mem_read_i && mem_reg_write_i;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    hz_operand_match #(.REG_AW(REG_AW)) u_match (
      .used_i         (used[g]),
      .src_i          (src[g]),
      .ex_wr_i        (ex_reg_write_i),
      .ex_load_i      (ex_load),
      .ex_dst_i       (ex_dst_i),
      .mem_load_i     (mem_load),
      .mem_dst_i      (mem_dst_i),
      .hit_ex_o       (hit_ex[g]),
      .hit_ex_load_o  (hit_ex_load[g]),
      .hit_mem_load_o (hit_mem_load[g])
    );
  end

  hz_stall_detect #(.N_OPS(N_OPS)) u_stall (
    .hit_ex_i       (hit_ex),
    .hit_ex_load_i  (hit_ex_load),
    .hit_mem_load_i (hit_mem_load),
    .id_is_branch_i (id_is_branch_i),
    .stall_o        (stall),
    .cause_o        (cause)
  );

  hz_redirect #(.OPC_W(OPC_W), .JUMP_OPC(JUMP_OPC)) u_redir (
    .if_opcode_i    (if_opcode_i),
    .id_is_branch_i (id_is_branch_i),
    .id_br_taken_i  (id_br_taken_i),
    .stall_i        (stall),
    .flush_o        (flush_raw),
    .jump_o         (jump_raw)
  );

  // reset freezes the pipe and feeds bubbles
  assign pc_we_o         = rst_ni && !stall;
  assign ifid_we_o       = rst_ni && !stall;
  assign idex_bubble_o   = !rst_ni || stall;
  assign ifid_flush_o    = rst_ni && flush_raw;
  assign jump_redirect_o = rst_ni && jump_raw;

  a_r1_load_use_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause == CAUSE_LOAD_USE) |-> (!pc_we_o && !ifid_we_o && idex_bubble_o));
  a_r2_branch_ex_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_is_branch_i && ex_reg_write_i && ex_dst_i != '0 &&
     ((id_use_rs_i && id_rs_i == ex_dst_i) || (id_use_rt_i && id_rt_i == ex_dst_i)))
    |-> idex_bubble_o);
  a_r5_zero_dst_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_dst_i == '0 && mem_dst_i == '0) |-> !idex_bubble_o);
  a_r7_flush_needs_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ifid_flush_o |-> (id_is_branch_i && id_br_taken_i && pc_we_o && ifid_we_o));
  a_r8_stall_over_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idex_bubble_o |-> !ifid_flush_o);
  a_r9_jump_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_redirect_o |-> (pc_we_o && !ifid_flush_o && if_opcode_i == JUMP_OPC));
endmodule

// File: tb/hazard_ctrl_tb.sv
module hazard_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] if_opc;
  logic [4:0] id_rs, id_rt, ex_dst, mem_dst;
  logic id_urs, id_urt, id_br, id_tk, ex_rw, ex_mr, mem_rw, mem_mr;
  logic pc_we, ifid_we, bub, fl, jr;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hazard_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .if_opcode_i(if_opc),
    .id_rs_i(id_rs), .id_rt_i(id_rt), .id_use_rs_i(id_urs), .id_use_rt_i(id_urt),
    .id_is_branch_i(id_br), .id_br_taken_i(id_tk),
    .ex_reg_write_i(ex_rw), .ex_mem_read_i(ex_mr), .ex_dst_i(ex_dst),
    .mem_reg_write_i(mem_rw), .mem_mem_read_i(mem_mr), .mem_dst_i(mem_dst),
    .pc_we_o(pc_we), .ifid_we_o(ifid_we), .idex_bubble_o(bub),
    .ifid_flush_o(fl), .jump_redirect_o(jr)
  );

  // all stages hold bubbles (all-zero words)
  task automatic clr();
    if_opc = 6'd0; id_rs = 0; id_rt = 0; id_urs = 0; id_urt = 0;
    id_br = 0; id_tk = 0; ex_rw = 0; ex_mr = 0; ex_dst = 0;
    mem_rw = 0; mem_mr = 0; mem_dst = 0;
  endtask

  task automatic set_id(input logic [4:0] rs, input logic [4:0] rt, input logic br, input logic tk);
    id_rs = rs; id_rt = rt; id_urs = 1; id_urt = 1; id_br = br; id_tk = tk;
  endtask

  // expected vector: {pc_we, ifid_we, bubble, flush, jump}
  task automatic chk(input string tag, input logic [4:0] exp);
    logic [4:0] act;
    @(negedge clk); #1;
    act = {pc_we, ifid_we, bub, fl, jr};
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  localparam logic [4:0] RUN   = 5'b11000;
  localparam logic [4:0] STALL = 5'b00100;
  localparam logic [4:0] FLUSH = 5'b11010;
  localparam logic [4:0] JUMP  = 5'b11001;

  task automatic t_reset();
    clr(); if_opc = 6'b000010; set_id(5'd3, 5'd4, 1, 1);
    chk("R12 reset freeze", STALL);
  endtask

  task automatic t_idle();
    clr(); set_id(5'd3, 5'd4, 0, 0);
    ex_rw = 1; ex_dst = 5'd9; mem_rw = 1; mem_dst = 5'd10;
    chk("R10 no hazard", RUN);
  endtask

  // lw r5 ; add r6,r5,r7 : one stall, then load in MEM forwards
  task automatic t_load_use();
    clr(); set_id(5'd5, 5'd7, 0, 0);
    ex_rw = 1; ex_mr = 1; ex_dst = 5'd5;
    chk("R1 load-use cycle1", STALL);
    ex_rw = 0; ex_mr = 0; ex_dst = 0; mem_rw = 1; mem_mr = 1; mem_dst = 5'd5;
    chk("R4 load in MEM no stall", RUN);
    clr(); set_id(5'd1, 5'd5, 0, 0); ex_rw = 1; ex_mr = 1; ex_dst = 5'd5;
    chk("R1 load-use via rt", STALL);
  endtask

  // lw r8 ; beq r8,r2 : two stalls
  task automatic t_load_branch();
    clr(); set_id(5'd8, 5'd2, 1, 1);
    ex_rw = 1; ex_mr = 1; ex_dst = 5'd8;
    chk("R2 load-branch cycle1 (R8 stall over taken)", STALL);
    ex_rw = 0; ex_mr = 0; ex_dst = 0; mem_rw = 1; mem_mr = 1; mem_dst = 5'd8;
    chk("R3 load-branch cycle2 (R8)", STALL);
    mem_rw = 0; mem_mr = 0; mem_dst = 0;
    chk("R7 resolved taken flush", FLUSH);
  endtask

  // add r4 ; beq r4 : one stall
  task automatic t_alu_branch();
    clr(); set_id(5'd2, 5'd4, 1, 0);
    ex_rw = 1; ex_dst = 5'd4;
    chk("R2 alu-branch cycle1", STALL);
    ex_rw = 0; ex_dst = 0; mem_rw = 1; mem_dst = 5'd4;
    chk("R3 alu in MEM no stall, R11 not taken", RUN);
  endtask

  task automatic t_alu_nonbranch();
    clr(); set_id(5'd4, 5'd2, 0, 0); ex_rw = 1; ex_dst = 5'd4;
    chk("R4 ex alu forwards", RUN);
  endtask

  task automatic t_zero_unused();
    clr(); set_id(5'd0, 5'd0, 1, 0); ex_rw = 1; ex_mr = 1; ex_dst = 5'd0;
    chk("R5 r0 load no stall", RUN);
    clr(); set_id(5'd6, 5'd6, 1, 0); id_urs = 0; id_urt = 0;
    ex_rw = 1; ex_mr = 1; ex_dst = 5'd6;
    chk("R6 unused sources no stall", RUN);
    id_urt = 1;
    chk("R6 used rt stalls", STALL);
  endtask

  task automatic t_jump();
    clr(); if_opc = 6'b000010;
    chk("R9 jump redirect", JUMP);
    if_opc = 6'b000011;
    chk("R9 near opcode no redirect", RUN);
    if_opc = 6'b000010; set_id(5'd4, 5'd1, 0, 0); ex_rw = 1; ex_mr = 1; ex_dst = 5'd4;
    chk("R9 jump held under stall", STALL);
    clr(); if_opc = 6'b000010; set_id(5'd1, 5'd2, 1, 1);
    chk("R9 jump squashed by taken branch", FLUSH);
  endtask

  initial begin
    clr();
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_idle();
    t_load_use();
    t_load_branch();
    t_alu_branch();
    t_alu_nonbranch();
    t_zero_unused();
    t_jump();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule